// File: doc/BRIEF.md
# Divided-Clock Register Access Bridge

This bridge connects a register bus running on the full system clock to a small register file that belongs to a slower peripheral. The peripheral's clock enable is made by dividing the system clock by 1, 2, 4 or 8. Writes are accepted at once on every cycle. With a division above one, the written value is first held in a single staging slot and moves into the register file only after a settling window of (ratio − 1) system cycles. Reads return the contents of the register file through a registered response one cycle after they are accepted.

While a write is settling, the bridge remembers which register it targets. A read of that register, or a read-modify-write of it, is held off by dropping `req_ready` until the window closes. Any other register can be read or written with no delay. If a new write arrives while a window is open, the staged value is moved into the register file on that same edge and the window restarts for the new address.

A two-state controller manages the interlock. `HZ_IDLE` means nothing is pending. `HZ_HOLD` means a staged write is counting down. It has four named transitions. *arm* goes from `HZ_IDLE` to `HZ_HOLD` on a write when the ratio is above one. *reload* goes from `HZ_HOLD` to `HZ_HOLD` on a further write, which flushes the staged value and restarts the count. *drain* goes from `HZ_HOLD` to `HZ_HOLD` while the count is still above one. *retire* goes from `HZ_HOLD` to `HZ_IDLE` when the count finishes, or when a write arrives while the ratio is one.

Top module: `divclk_reg_bridge`

## Requirements
- R1: After reset the division ratio is 1, no write is pending, `req_ready` is high, `rsp_valid` is low, `periph_ce` is high every cycle, and every register reads as zero.
- R2: A request with `req_op` = 1 (plain write) is always accepted in the cycle it is presented, whatever the pending state.
- R3: With `div_sel` = 0 (ratio 1), a read of a register presented in the cycle right after a write to it is accepted without stall and returns the new value.
- R4: With `div_sel` = 1, 2 or 3 (ratio 2, 4 or 8), a read of the register just written is stalled for exactly 1, 3 or 7 cycles respectively, and then returns the new value.
- R5: During a settling window, reads of any register other than the pending one are accepted without stall and return the register file's committed contents.
- R6: Read-modify-write ops (`req_op` 2 = AND, 3 = OR, 4 = XOR with `req_wdata`) return the old value in the response and store the combined result. They stall against a pending write exactly like reads, and start a new window like writes. Codes 0 and 5–7 are plain reads.
- R7: A write during an open window commits the previously staged value on the same edge, so that value is readable without stall from the next cycle. The window restarts with the new address and the full (ratio − 1) count. A second write to the same address replaces the staged value.
- R8: `periph_ce` is high in the first cycle after the registered ratio changes, and then once every ratio cycles. The registered ratio follows `div_sel` with one cycle of delay.
- R9: A response appears on `rsp_rdata` with `rsp_valid` high exactly one cycle after a read or read-modify-write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Ratio select: 0=/1, 1=/2, 2=/4, 3=/8 |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | 0 read, 1 write, 2 AND, 3 OR, 4 XOR, others read |
| req_addr | input | AW | Register index |
| req_wdata | input | DW | Write data or modify operand |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | DW | Read response data |
| periph_ce | output | 1 | Divided clock enable for the peripheral |

## Verification
Two things can coincide on the same clock edge: the countdown reaching its end, and a new write that would flush the staged value. This is provoked at ratio 4 by writing one register, idling two cycles so that the count is down to one, and then writing a second register on the very edge where the window would otherwise retire. The outcome is judged by reading the first register with no stall allowed, which must return its new value, and then reading the second register. That read must stall for the remaining restarted count and return the second value.

// File: rtl/bridge_pkg.sv
`timescale 1ns/1ps
package bridge_pkg;

    localparam int SEL_W = 2;
    localparam int CNT_W = 3;
    localparam int OP_W  = 3;

    typedef enum logic [OP_W-1:0] {
        OP_RD  = 3'd0,
        OP_WR  = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } op_e;

    typedef enum logic {
        HZ_IDLE = 1'b0,
        HZ_HOLD = 1'b1
    } hz_state_e;

    function automatic logic [CNT_W-1:0] sel_to_m1(input logic [SEL_W-1:0] s);
        logic [CNT_W-1:0] r;
        unique case (s)
            2'd0:    r = 3'd0;
            2'd1:    r = 3'd1;
            2'd2:    r = 3'd3;
            default: r = 3'd7;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bridge_clkdiv.sv
`timescale 1ns/1ps
module bridge_clkdiv
    import bridge_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic [CNT_W-1:0] ratio_m1,
    output logic             ce
);

    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] ce_cnt;

    assign ratio_m1 = sel_to_m1(sel_q);
    assign ce       = (ce_cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            ce_cnt <= '0;
        end else begin
            sel_q <= div_sel;
            if (div_sel != sel_q)
                ce_cnt <= '0;
            else if (ce_cnt >= ratio_m1)
                ce_cnt <= '0;
            else
                ce_cnt <= ce_cnt + 1'b1;
        end
    end

    // R8
    ce_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != $past(sel_q)) |-> ce);

    // R8
    ce_unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == '0) |-> ce);

endmodule

// File: rtl/bridge_hazard.sv
`timescale 1ns/1ps
module bridge_hazard
    import bridge_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ratio_m1,
    input  logic             wr_fire,
    input  logic [AW-1:0]    wr_addr,
    input  logic             rd_req,
    input  logic [AW-1:0]    rd_addr,
    output logic             stall,
    output logic             stg_commit,
    output logic             busy,
    output logic [AW-1:0]    hold_addr
);

    hz_state_e        state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [AW-1:0]    addr_n;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= HZ_IDLE;
            cnt       <= '0;
            hold_addr <= '0;
        end else begin
            state     <= state_n;
            cnt       <= cnt_n;
            hold_addr <= addr_n;
        end
    end

    // next-state and output process
    always_comb begin
        state_n    = state;
        cnt_n      = cnt;
        addr_n     = hold_addr;
        stall      = 1'b0;
        stg_commit = 1'b0;
        busy       = 1'b0;
        unique case (state)
            HZ_IDLE: begin
                if (wr_fire && ratio_m1 != '0) begin
                    state_n = HZ_HOLD;   // arm
                    cnt_n   = ratio_m1;
                    addr_n  = wr_addr;
                end
            end
            HZ_HOLD: begin
                busy       = 1'b1;
                stall      = rd_req && (rd_addr == hold_addr);
                stg_commit = wr_fire || (cnt == 3'd1);
                if (wr_fire) begin
                    if (ratio_m1 != '0) begin
                        state_n = HZ_HOLD;   // reload
                        cnt_n   = ratio_m1;
                        addr_n  = wr_addr;
                    end else begin
                        state_n = HZ_IDLE;   // retire
                        cnt_n   = '0;
                    end
                end else if (cnt == 3'd1) begin
                    state_n = HZ_IDLE;       // retire
                    cnt_n   = '0;
                end else begin
                    state_n = HZ_HOLD;       // drain
                    cnt_n   = cnt - 1'b1;
                end
            end
            default: begin
                state_n = HZ_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // R4
    countdown_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HZ_HOLD && !wr_fire && cnt == 3'd1) |=> (state == HZ_IDLE));

    // R7
    window_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && ratio_m1 != '0) |=>
            (state == HZ_HOLD && cnt == $past(ratio_m1) && hold_addr == $past(wr_addr)));

    // R3
    unity_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HZ_IDLE && wr_fire && ratio_m1 == '0) |=> (state == HZ_IDLE));

endmodule

// File: rtl/bridge_regfile.sv
`timescale 1ns/1ps
module bridge_regfile #(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          direct_we,
    input  logic          stg_load,
    input  logic          stg_commit,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int NREG = 1 << AW;

    logic [AW-1:0] stg_addr;
    logic [DW-1:0] stg_data;
    logic [DW-1:0] mem [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_addr <= '0;
            stg_data <= '0;
        end else if (stg_load) begin
            stg_addr <= wr_addr;
            stg_data <= wr_data;
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : g_ent
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (direct_we && wr_addr == AW'(i))
                q <= wr_data;
            else if (stg_commit && stg_addr == AW'(i))
                q <= stg_data;
        end
        assign mem[i] = q;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/divclk_reg_bridge.sv
`timescale 1ns/1ps
module divclk_reg_bridge
    import bridge_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    div_sel,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          periph_ce
);

    logic [CNT_W-1:0] ratio_m1;
    logic             is_wr, is_rmw, needs_read;
    logic             stall, stg_commit, busy;
    logic [AW-1:0]    hold_addr;
    logic             fire, wr_fire, rd_fire;
    logic [DW-1:0]    old_data, new_data;

    assign is_wr      = (req_op == OP_WR);
    assign is_rmw     = (req_op == OP_AND) || (req_op == OP_OR) || (req_op == OP_XOR);
    assign needs_read = !is_wr;
    assign req_ready  = !stall;
    assign fire       = req_valid && req_ready;
    assign wr_fire    = fire && (is_wr || is_rmw);
    assign rd_fire    = fire && needs_read;

    always_comb begin
        unique case (req_op)
            OP_AND:  new_data = old_data & req_wdata;
            OP_OR:   new_data = old_data | req_wdata;
            OP_XOR:  new_data = old_data ^ req_wdata;
            default: new_data = req_wdata;
        endcase
    end

    bridge_clkdiv u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_sel  (div_sel),
        .ratio_m1 (ratio_m1),
        .ce       (periph_ce)
    );

    bridge_hazard #(.AW(AW)) u_hz (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_m1   (ratio_m1),
        .wr_fire    (wr_fire),
        .wr_addr    (req_addr),
        .rd_req     (req_valid && needs_read),
        .rd_addr    (req_addr),
        .stall      (stall),
        .stg_commit (stg_commit),
        .busy       (busy),
        .hold_addr  (hold_addr)
    );

    bridge_regfile #(.AW(AW), .DW(DW)) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .direct_we  (wr_fire && ratio_m1 == '0),
        .stg_load   (wr_fire && ratio_m1 != '0),
        .stg_commit (stg_commit),
        .wr_addr    (req_addr),
        .wr_data    (new_data),
        .rd_addr    (req_addr),
        .rd_data    (old_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_fire;
            if (rd_fire)
                rsp_rdata <= old_data;
        end
    end

    // R2
    write_never_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_WR) |-> req_ready);

    // R5
    other_reg_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy && req_addr != hold_addr) |-> req_ready);

    // R4
    match_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy && needs_read && req_addr == hold_addr) |-> !req_ready);

endmodule

// File: tb/test_divclk_reg_bridge.sv
`timescale 1ns/1ps
module test_divclk_reg_bridge;

    localparam int AW = 3;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    div_sel = '0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid, periph_ce;
    logic [DW-1:0] rsp_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [DW-1:0] model [1 << AW];
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];

    always #10 clk = ~clk;

    divclk_reg_bridge #(.AW(AW), .DW(DW)) i_divclk_reg_bridge (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .periph_ce(periph_ce)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected responses
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected response", int'(rsp_rdata), -1);
            end else begin
                automatic logic [DW-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rsp_rdata === e, t, int'(rsp_rdata), int'(e));
            end
        end
    end

    // driver: one request, counts stall cycles
    task automatic req(input logic [2:0] op, input int addr, input logic [DW-1:0] d,
                       input int exp_stall, input string tag);
        int stalls = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = AW'(addr);
        req_wdata = d;
        #5;
        while (!req_ready && stalls < 20) begin
            stalls++;
            @(negedge clk);
            #5;
        end
        check(stalls == exp_stall, {tag, " stall count"}, stalls, exp_stall);
        if (op != 3'd1) begin
            exp_q.push_back(model[addr]);
            tag_q.push_back({tag, " read data"});
        end
        case (op)
            3'd1: model[addr] = d;
            3'd2: model[addr] = model[addr] & d;
            3'd3: model[addr] = model[addr] | d;
            3'd4: model[addr] = model[addr] ^ d;
            default: ;
        endcase
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // R8: change ratio and watch the enable pattern
    task automatic ce_check(input logic [1:0] sel);
        int ratio = 1 << sel;
        int bad = 0;
        idle(1);
        div_sel = sel;
        for (int k = 0; k < 17; k++) begin
            @(negedge clk);
            if (periph_ce !== ((k % ratio) == 0)) bad++;
        end
        check(bad == 0, "R8 periph_ce pattern", bad, 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready === 1'b1, "R1 ready", int'(req_ready), 1);
        check(rsp_valid === 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        check(periph_ce === 1'b1, "R1 periph_ce", int'(periph_ce), 1);
        req(3'd0, 5, 8'h00, 0, "R1");

        // R3 ratio 1
        req(3'd1, 2, 8'h3C, 0, "R2");
        req(3'd0, 2, 8'h00, 0, "R3");

        // R4 / R5 ratio 2
        ce_check(2'd1);
        req(3'd1, 1, 8'hA5, 0, "R2");
        req(3'd0, 1, 8'h00, 1, "R4");
        req(3'd1, 3, 8'h5A, 0, "R2");
        req(3'd0, 0, 8'h00, 0, "R5");
        req(3'd0, 3, 8'h00, 0, "R5");

        // ratio 4
        ce_check(2'd2);
        req(3'd1, 4, 8'h11, 0, "R2");
        req(3'd0, 4, 8'h00, 3, "R4");
        req(3'd1, 6, 8'h77, 0, "R2");
        req(3'd0, 2, 8'h00, 0, "R5");
        req(3'd0, 4, 8'h00, 0, "R5");
        idle(4);
        // R7 write lands on the edge the window would retire
        req(3'd1, 0, 8'hF0, 0, "R2");
        idle(2);
        req(3'd1, 7, 8'h0F, 0, "R7");
        req(3'd0, 0, 8'h00, 0, "R7");
        req(3'd0, 7, 8'h00, 2, "R7");
        // R7 same-address rewrite
        req(3'd1, 1, 8'h01, 0, "R2");
        req(3'd1, 1, 8'h02, 0, "R7");
        req(3'd0, 1, 8'h00, 3, "R7");

        // ratio 8 with read-modify-write
        ce_check(2'd3);
        req(3'd1, 5, 8'hC3, 0, "R2");
        req(3'd0, 5, 8'h00, 7, "R4");
        req(3'd2, 5, 8'h0F, 0, "R6");
        req(3'd3, 5, 8'h80, 7, "R6");
        req(3'd0, 5, 8'h00, 7, "R6");
        req(3'd4, 2, 8'hFF, 0, "R6");
        req(3'd6, 2, 8'h00, 7, "R6");

        // back to ratio 1
        ce_check(2'd0);
        req(3'd1, 6, 8'h99, 0, "R2");
        req(3'd0, 6, 8'h00, 0, "R3");
        idle(4);
        check(exp_q.size() == 0, "R9 responses outstanding", exp_q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule